// File: doc/BRIEF.md
# Interval Timer Host Register Port

This block sits between a byte-wide host bus and the three counting engines of a programmable interval timer. The host reaches three counter ports (addresses 0, 1, 2) and one control port (address 3). Through the control port it programs each channel's byte access order, counting mode and decimal flag. The same port carries commands that freeze a channel's count or status for a later read.

A data write to a counter port is assembled into a 16-bit reload value according to the channel's access order. The block then hands the value to that channel's engine with a single-cycle load strobe.

A read from a counter port returns one of three things, in this order of priority: a pending status snapshot, a pending count snapshot, or the live count. Each is returned one byte at a time in the channel's configured order. The counting engines are outside this block. It only receives each engine's live count and output level, and it stores and reports the decimal flag without acting on it.

Top module: `tmr_host_port`

## Requirements
- R1: After reset no load strobe is active and `rdata` is 0x00. Every channel starts in counting mode 0 with access code 3 (low byte then high byte), its decimal flag clear, and no snapshot pending.
- R2: A control-port write with channel field (bits 7:6) equal to 0–2 and a nonzero access field (bits 5:4) stores the access code, the counting mode (bits 3:1) and the decimal flag (bit 0) for that channel. A control-port write never raises a load strobe.
- R3: With access code 1 (low byte only), each data write loads {8'h00, byte} into the channel.
- R4: With access code 2 (high byte only), each data write loads {byte, 8'h00} into the channel.
- R5: With access code 3, the first data byte is only held in a holding register. The second data byte loads {second, first}, and the next byte is again taken as a low byte.
- R6: A control word that programs a channel restarts that channel's write sequence and read sequence at the low byte.
- R7: An access field of 0 takes a snapshot of the channel's live count and leaves its access code and mode unchanged. Reads return the snapshot in the channel's byte order: with code 3, the low byte and then the high byte. After that, reads return the live count again.
- R8: A count snapshot request is ignored while a count snapshot is still pending on that channel. A status snapshot request is likewise ignored while a status snapshot is pending.
- R9: A control word with channel field 3 is a multi-channel command. Bits 1, 2 and 3 select channels 0, 1 and 2. For each selected channel, bit 5 = 0 takes a count snapshot and bit 4 = 0 takes a status snapshot.
- R10: The status byte is {output level, 1'b0, access code, mode, decimal flag}, with bit 7 at the left. A pending status snapshot is returned by the next read before any pending count snapshot.
- R11: With no snapshot pending, reads return the live count: code 1 returns the low byte, code 2 the high byte, and code 3 alternates low and high, starting with the low byte.
- R12: The read byte appears on `rdata` one clock after the read strobe and holds until the next read. A read of the control port returns 0x00. A load strobe is a single-cycle pulse on exactly one channel, one clock after the data write that completes a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | 0–2 counter ports, 3 control port |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| live_cnt | input | 48 | Live counts of channels 2,1,0 (16 bits each, channel 0 lowest) |
| out_lvl | input | 3 | Output levels of the channel engines |
| load_stb | output | 3 | Per-channel reload strobe |
| load_val | output | 48 | Per-channel reload values (channel 0 lowest) |

## Verification
Two results have fixed latency. A read byte lands in `rdata` one clock after the read strobe is sampled. A completed write raises `load_stb` and updates `load_val` one clock after the write strobe. The bench drives each strobe for exactly one cycle starting at a falling edge and samples at the following falling edge, so exactly one rising edge separates stimulus from observation. Snapshots capture `live_cnt` and `out_lvl` on the edge that accepts the command. The bench therefore changes those inputs only after that edge, so a returned value that matches the new input shows that the snapshot was missed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH  = 3;
    localparam int BW   = 8;
    localparam int CW   = 2 * BW;
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    // count snapshot pending state; values line up with acc_e
    typedef enum logic [1:0] {
        SNP_NONE = 2'd0,
        SNP_LO   = 2'd1,
        SNP_HI   = 2'd2,
        SNP_WORD = 2'd3
    } snap_e;

    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{acc: ACC_WORD, mode: 3'd0, bcd: 1'b0};

    function automatic logic [BW-1:0] status_of(logic lvl, chan_cfg_t c);
        return {lvl, 1'b0, c.acc, c.mode, c.bcd};
    endfunction
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_pkg::*;
(
    input  logic                 ctrl_we,
    input  logic [BW-1:0]        cw,
    output chan_cfg_t            cfg_new,
    output logic [NCH-1:0]       prog,
    output logic [NCH-1:0]       cnt_req,
    output logic [NCH-1:0]       stat_req
);
    logic [1:0] sel;
    logic [1:0] acc_f;
    logic       multi;

    assign sel   = cw[7:6];
    assign acc_f = cw[5:4];
    assign multi = (sel == 2'd3);

    always_comb begin
        cfg_new  = '{acc: acc_e'(acc_f), mode: cw[3:1], bcd: cw[0]};
        prog     = '0;
        cnt_req  = '0;
        stat_req = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ctrl_we) begin
                if (multi) begin
                    if (cw[i+1]) begin
                        cnt_req[i]  = !cw[5];
                        stat_req[i] = !cw[4];
                    end
                end else if (sel == 2'(i)) begin
                    if (acc_f == 2'd0) cnt_req[i] = 1'b1;
                    else               prog[i]    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           prog,
    input  chan_cfg_t      cfg_new,
    input  logic           cnt_req,
    input  logic           stat_req,
    input  logic           wr,
    input  logic           rd,
    input  logic [BW-1:0]  wdata,
    input  logic [CW-1:0]  live,
    input  logic           lvl,
    output logic           load_stb,
    output logic [CW-1:0]  load_val,
    output logic [BW-1:0]  rd_byte
);
    chan_cfg_t      cfg;
    logic           wr_hi, rd_hi;
    logic [BW-1:0]  hold_lo;
    snap_e          snap;
    logic [CW-1:0]  snap_val;
    logic           st_pend;
    logic [BW-1:0]  st_val;

    always_comb begin
        if (st_pend)
            rd_byte = st_val;
        else if (snap != SNP_NONE)
            rd_byte = (snap == SNP_HI) ? snap_val[CW-1:BW] : snap_val[BW-1:0];
        else begin
            case (cfg.acc)
                ACC_HI:   rd_byte = live[CW-1:BW];
                ACC_WORD: rd_byte = rd_hi ? live[CW-1:BW] : live[BW-1:0];
                default:  rd_byte = live[BW-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= CFG_RESET;
            wr_hi    <= 1'b0;
            rd_hi    <= 1'b0;
            hold_lo  <= '0;
            snap     <= SNP_NONE;
            snap_val <= '0;
            st_pend  <= 1'b0;
            st_val   <= '0;
            load_stb <= 1'b0;
            load_val <= '0;
        end else begin
            load_stb <= 1'b0;
            if (rd) begin
                if (st_pend)
                    st_pend <= 1'b0;
                else if (snap != SNP_NONE)
                    snap <= (snap == SNP_WORD) ? SNP_HI : SNP_NONE;
                else if (cfg.acc == ACC_WORD)
                    rd_hi <= !rd_hi;
            end
            if (wr) begin
                case (cfg.acc)
                    ACC_LO: begin
                        load_stb <= 1'b1;
                        load_val <= {{BW{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load_stb <= 1'b1;
                        load_val <= {wdata, {BW{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (wr_hi) begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, hold_lo};
                        end else begin
                            hold_lo <= wdata;
                        end
                        wr_hi <= !wr_hi;
                    end
                    default: ;
                endcase
            end
            if (prog) begin
                cfg   <= cfg_new;
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end
            if (cnt_req && snap == SNP_NONE) begin
                snap     <= snap_e'(cfg.acc);
                snap_val <= live;
            end
            if (stat_req && !st_pend) begin
                st_pend <= 1'b1;
                st_val  <= status_of(lvl, cfg);
            end
        end
    end
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [NCH*CW-1:0]    live_cnt,
    input  logic [NCH-1:0]       out_lvl,
    output logic [NCH-1:0]       load_stb,
    output logic [NCH*CW-1:0]    load_val
);
    chan_cfg_t       cfg_new;
    logic [NCH-1:0]  prog, cnt_req, stat_req;
    logic [BW-1:0]   ch_byte [NCH];
    logic            ctrl_we;

    assign ctrl_we = wr_en && (addr == CTRL_ADDR);

    tmr_ctrl_decode i_dec (
        .ctrl_we  (ctrl_we),
        .cw       (wdata),
        .cfg_new  (cfg_new),
        .prog     (prog),
        .cnt_req  (cnt_req),
        .stat_req (stat_req)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan_port i_ch (
            .clk      (clk),
            .rst      (rst),
            .prog     (prog[g]),
            .cfg_new  (cfg_new),
            .cnt_req  (cnt_req[g]),
            .stat_req (stat_req[g]),
            .wr       (wr_en && addr == 2'(g)),
            .rd       (rd_en && addr == 2'(g)),
            .wdata    (wdata),
            .live     (live_cnt[g*CW +: CW]),
            .lvl      (out_lvl[g]),
            .load_stb (load_stb[g]),
            .load_val (load_val[g*CW +: CW]),
            .rd_byte  (ch_byte[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                2'd0:    rdata <= ch_byte[0];
                2'd1:    rdata <= ch_byte[1];
                2'd2:    rdata <= ch_byte[2];
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_port_chk.sv
module tmr_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic [2:0] load_stb
);
    a_r12_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_stb));

    a_r12_load_from_write: assert property (@(posedge clk) disable iff (rst)
        (|load_stb) |-> $past(wr_en && addr != 2'd3));

    a_r2_ctrl_no_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=> (load_stb == 3'b000));

    a_r12_ctrl_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd3) |=> (rdata == 8'h00));

    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |=> $stable(rdata));
endmodule

bind tmr_host_port tmr_port_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .load_stb (load_stb)
);

// File: tb/test_tmr_host_port.sv
`timescale 1ns/1ps
module test_tmr_host_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = '0;
    logic [2:0]  out_lvl = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_val;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tmr_host_port i_tmr_host_port (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .out_lvl(out_lvl),
        .load_stb(load_stb), .load_val(load_val)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write one byte; returns strobe/value seen one clock later
    task automatic wr(input logic [1:0] a, input logic [7:0] d,
                      output logic [2:0] stb, output logic [47:0] val);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        stb = load_stb; val = load_val;
        wr_en = 1'b0;
    endtask

    task automatic wrc(input logic [7:0] d);
        logic [2:0] s; logic [47:0] v;
        wr(2'd3, d, s, v);
        check("R2 ctrl no strobe", {29'd0, s}, 32'd0);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic t_reset();
        check("R1 rdata", {24'd0, rdata}, 32'd0);
        check("R1 strobe", {29'd0, load_stb}, 32'd0);
        out_lvl = 3'b001;
        wrc(8'hE2);                         // status snapshot ch0 only
        rd_chk("R1 status defaults", 2'd0, 8'hB0);
        out_lvl = 3'b000;
    endtask

    task automatic t_low_only();
        logic [2:0] s; logic [47:0] v;
        wrc(8'h54);                         // ch1 access1 mode2
        wr(2'd1, 8'hA5, s, v);
        check("R3 strobe", {29'd0, s}, 32'b010);
        check("R3 value", {16'd0, v[31:16]}, 32'h00A5);
        @(negedge clk);
        check("R12 strobe single cycle", {29'd0, load_stb}, 32'd0);
    endtask

    task automatic t_high_only();
        logic [2:0] s; logic [47:0] v;
        wrc(8'hA6);                         // ch2 access2 mode3
        wr(2'd2, 8'h3C, s, v);
        check("R4 strobe", {29'd0, s}, 32'b100);
        check("R4 value", {16'd0, v[47:32]}, 32'h3C00);
    endtask

    task automatic t_word();
        logic [2:0] s; logic [47:0] v;
        wrc(8'h34);                         // ch0 access3 mode2
        wr(2'd0, 8'h11, s, v);
        check("R5 first byte no load", {29'd0, s}, 32'd0);
        wr(2'd0, 8'h22, s, v);
        check("R5 strobe", {29'd0, s}, 32'b001);
        check("R5 value", {16'd0, v[15:0]}, 32'h2211);
        wr(2'd0, 8'h33, s, v);
        check("R5 back to low", {29'd0, s}, 32'd0);
        wr(2'd0, 8'h44, s, v);
        check("R5 second word", {16'd0, v[15:0]}, 32'h4433);
    endtask

    task automatic t_resequence();
        logic [2:0] s; logic [47:0] v;
        wrc(8'h34);
        wr(2'd0, 8'h77, s, v);
        wrc(8'h34);                         // restart sequence
        wr(2'd0, 8'h55, s, v);
        check("R6 write restart no load", {29'd0, s}, 32'd0);
        wr(2'd0, 8'h66, s, v);
        check("R6 write restart value", {16'd0, v[15:0]}, 32'h6655);
        live_cnt[15:0] = 16'hBEEF;
        rd_chk("R11 word low", 2'd0, 8'hEF);
        wrc(8'h34);
        rd_chk("R6 read restart low", 2'd0, 8'hEF);
        rd_chk("R11 word high", 2'd0, 8'hBE);
        rd_chk("R11 word low again", 2'd0, 8'hEF);
    endtask

    task automatic t_live_modes();
        live_cnt[31:16] = 16'h1234;
        live_cnt[47:32] = 16'hABCD;
        rd_chk("R11 low only", 2'd1, 8'h34);
        rd_chk("R11 low only repeat", 2'd1, 8'h34);
        rd_chk("R11 high only", 2'd2, 8'hAB);
        rd_chk("R12 control read", 2'd3, 8'h00);
    endtask

    task automatic t_snapshot();
        wrc(8'h34);
        live_cnt[15:0] = 16'h1357;
        wrc(8'h00);                         // count snapshot ch0
        live_cnt[15:0] = 16'h9988;
        rd_chk("R7 snap low", 2'd0, 8'h57);
        rd_chk("R7 snap high", 2'd0, 8'h13);
        rd_chk("R7 live after snap", 2'd0, 8'h88);
        rd_chk("R7 live high", 2'd0, 8'h99);
        wrc(8'hE2);
        rd_chk("R7 config unchanged", 2'd0, 8'h34);
    endtask

    task automatic t_ignore();
        live_cnt[15:0] = 16'h0102;
        wrc(8'h00);
        live_cnt[15:0] = 16'h0304;
        wrc(8'h00);                         // ignored: still pending
        rd_chk("R8 count kept low", 2'd0, 8'h02);
        rd_chk("R8 count kept high", 2'd0, 8'h01);
        out_lvl[0] = 1'b1;
        wrc(8'hE2);
        out_lvl[0] = 1'b0;
        wrc(8'hE2);                         // ignored
        rd_chk("R8 status kept", 2'd0, 8'hB4);
        rd_chk("R8 status cleared", 2'd0, 8'h04);
    endtask

    task automatic t_multi();
        wrc(8'hB1);                         // ch2 access3 mode0 bcd
        out_lvl = 3'b010;
        live_cnt[31:16] = 16'h00AA;
        live_cnt[47:32] = 16'h4321;
        wrc(8'hCC);                         // multi: count+status ch1,ch2
        out_lvl = 3'b000;
        live_cnt[31:16] = 16'h00BB;
        live_cnt[47:32] = 16'h0000;
        rd_chk("R10 status ch1", 2'd1, 8'h94);
        rd_chk("R9 count ch1", 2'd1, 8'hAA);
        rd_chk("R9 ch1 live after", 2'd1, 8'hBB);
        rd_chk("R10 status ch2 bcd", 2'd2, 8'h31);
        rd_chk("R9 count ch2 low", 2'd2, 8'h21);
        rd_chk("R9 count ch2 high", 2'd2, 8'h43);
        live_cnt[15:0] = 16'h5A5A;
        wrc(8'hD2);                         // count only, ch0
        live_cnt[15:0] = 16'h0000;
        rd_chk("R9 count only ch0", 2'd0, 8'h5A);
        rd_chk("R9 count only ch0 high", 2'd0, 8'h5A);
        rd_chk("R9 unselected ch1 live", 2'd1, 8'hBB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_low_only();
        t_high_only();
        t_word();
        t_resequence();
        t_live_modes();
        t_snapshot();
        t_ignore();
        t_multi();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule